// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 30-bit virtual page number into a 21-bit physical page number by reading three page table entries in turn from memory. A request brings the virtual page number, the kind of access (read, write or execute) and the physical page of the top-level table. The walker then issues one 64-bit entry read per level on a simple request/response memory port. Each level's table address is formed only by joining bit fields, so no adder sits in the address path.

Each entry it reads is checked. An entry whose valid bit is clear ends the walk with a page fault. An intermediate entry that does not grant read access ends the walk with a protection fault, because the next table cannot be read through it. On the last entry, the permission that the access type needs is checked. A walk that passes every check returns the physical page number and the three permission bits of the last entry. Every outcome is reported as a single-cycle pulse. A new request can be accepted in that same reporting cycle.

Top module: `pt_walker`

## Requirements
- R1: A request is accepted when `req_valid` is high and `busy` is low. `busy` is high from the cycle after acceptance up to, but not including, the reporting cycle. A request that arrives while `busy` is high is ignored and does not change any address the current walk issues.
- R2: The entry address for a level is {table physical page, 10-bit index, 3'b000}, which equals page×8192 + index×8. Level 1 uses the request's base page and virtual page bits 29:20. Level 2 uses bits 19:10 and the page from the level 1 entry. Level 3 uses bits 9:0 and the page from the level 2 entry.
- R3: The walker has at most one read outstanding. `mem_req_valid` is high for exactly one cycle per level, and the next read is issued only after the response has been taken. A response that arrives while no read is outstanding is ignored.
- R4: The entry layout is: bit 0 is valid, bit 1 grants read, bit 2 grants write, bit 3 grants execute, and bits 63:43 hold the physical page number.
- R5: An entry with bit 0 clear at any level ends the walk. In the cycle after the response, `fault_page` pulses for one cycle with `fault_level` set to the level number (1, 2 or 3). No further read is issued. The valid check takes priority over the permission checks.
- R6: A valid level 1 or level 2 entry without the read bit ends the walk with a one-cycle `fault_prot` pulse, and `fault_level` gives that level.
- R7: On the level 3 entry, access code 00 (read) needs the read bit, 01 (write) needs the write bit, 10 (execute) needs the execute bit, and 11 is treated as a read. If the needed bit is missing, `fault_prot` pulses with `fault_level` = 3.
- R8: A walk that passes every check pulses `done_valid` for one cycle, in the cycle after the level 3 response. `done_ppn` carries entry bits 63:43 and `done_perm` carries entry bits 3:1.
- R9: During and after reset, `busy`, `mem_req_valid`, `done_valid`, `fault_page` and `fault_prot` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Walk request strobe |
| req_vpn | input | 30 | Virtual page number to translate |
| req_base | input | 21 | Physical page of the level 1 table |
| req_access | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 read |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Entry read request, one cycle per level |
| mem_req_addr | output | 34 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Entry read data is valid |
| mem_rsp_data | input | 64 | Entry read data |
| done_valid | output | 1 | Translation succeeded (pulse) |
| done_ppn | output | 21 | Translated physical page number |
| done_perm | output | 3 | Permissions of the last entry {execute, write, read} |
| fault_page | output | 1 | Walk ended on an invalid entry (pulse) |
| fault_prot | output | 1 | Walk ended on a missing permission (pulse) |
| fault_level | output | 2 | Level at which the walk faulted |

## Verification
The main coincidence is a result and a new request landing in the same cycle. The bench provokes it by driving the next request during the reporting cycle of the previous walk. It then judges that the result pulse is still correct and that the new walk's first read goes to the new base and index, not to a leftover table page. A second overlap comes from holding a stray request, with inverted fields, during every memory wait. The checks confirm that every level's address still follows the walk that was accepted. The permission sweep covers every combination of access code and final-entry permission bits, with varied memory latency.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  localparam int unsigned LEVELS    = 3;
  localparam int unsigned LVL_NUM_W = 2;
  localparam int unsigned PERM_W    = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1,
    ST_L2,
    ST_L3,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    ACC_READ     = 2'b00,
    ACC_WRITE    = 2'b01,
    ACC_EXEC     = 2'b10,
    ACC_READ_ALT = 2'b11
  } access_e;

  // Level number carried by a walking state; zero outside a walk.
  function automatic logic [LVL_NUM_W-1:0] state_level(walk_state_e s);
    case (s)
      ST_L1:   return LVL_NUM_W'(1);
      ST_L2:   return LVL_NUM_W'(2);
      ST_L3:   return LVL_NUM_W'(3);
      default: return '0;
    endcase
  endfunction

  // Permission bit that an access kind needs, laid out as {exec, write, read}.
  function automatic logic [PERM_W-1:0] need_mask(access_e a);
    case (a)
      ACC_WRITE: return 3'b010;
      ACC_EXEC:  return 3'b100;
      default:   return 3'b001;
    endcase
  endfunction

endpackage

// File: rtl/pt_index_mux.sv
module pt_index_mux
  import pt_walk_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned NLVL  = LEVELS
) (
  input  logic [IDX_W*NLVL-1:0] vpn,
  input  logic [LVL_NUM_W-1:0]  level,
  output logic [IDX_W-1:0]      idx
);

  logic [IDX_W-1:0] slice [NLVL];

  // Level 1 takes the most significant slice of the virtual page number.
  for (genvar g = 0; g < NLVL; g++) begin : g_slice
    assign slice[g] = vpn[(NLVL-1-g)*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (level == LVL_NUM_W'(i + 1)) idx = slice[i];
    end
  end

endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
  import pt_walk_pkg::*;
#(
  parameter int unsigned PTE_W = 64,
  parameter int unsigned PPN_W = 21
) (
  input  logic [PTE_W-1:0]  pte,
  input  logic              last_level,
  input  access_e           access,
  output logic [PERM_W-1:0] perm,
  output logic [PPN_W-1:0]  ppn,
  output logic              page_fault,
  output logic              prot_fault
);

  localparam int unsigned MID_LO = PERM_W + 1;
  localparam int unsigned MID_HI = PTE_W - PPN_W - 1;

  function automatic logic [PPN_W-1:0] field_ppn(logic [PTE_W-1:0] e);
    return e[PTE_W-1 -: PPN_W];
  endfunction

  function automatic logic [PERM_W-1:0] field_perm(logic [PTE_W-1:0] e);
    return e[PERM_W:1];
  endfunction

  logic              valid;
  logic [PERM_W-1:0] need;
  logic              unused_mid;

  assign valid      = pte[0];
  assign perm       = field_perm(pte);
  assign ppn        = field_ppn(pte);
  assign unused_mid = ^pte[MID_HI:MID_LO];

  // Intermediate entries must allow reading of the next table.
  assign need       = last_level ? need_mask(access) : PERM_W'(1);

  // The valid check comes first: an invalid entry never reports a protection fault.
  assign page_fault = !valid;
  assign prot_fault = valid && ((perm & need) != need);

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        rsp_valid,
  input  logic        ev_page,
  input  logic        ev_prot,
  output walk_state_e state_q,
  output logic        busy,
  output logic        mem_req_valid,
  output logic        accept,
  output logic        rsp_take
);

  walk_state_e state_d;
  logic        sent_q;

  assign busy          = (state_q == ST_L1) || (state_q == ST_L2) || (state_q == ST_L3);
  assign accept        = req_valid && !busy;
  assign mem_req_valid = busy && !sent_q;
  assign rsp_take      = busy && sent_q && rsp_valid;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_DONE, ST_FAULT: state_d = accept ? ST_L1 : ST_IDLE;
      ST_L1: if (rsp_take) state_d = (ev_page || ev_prot) ? ST_FAULT : ST_L2;
      ST_L2: if (rsp_take) state_d = (ev_page || ev_prot) ? ST_FAULT : ST_L3;
      ST_L3: if (rsp_take) state_d = (ev_page || ev_prot) ? ST_FAULT : ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sent_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept || rsp_take) sent_q <= 1'b0;
      else if (mem_req_valid) sent_q <= 1'b1;
    end
  end

  // R3: a read is issued once, then nothing until its response is taken.
  assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R1: a walk only starts on a request strobe.
  assert_busy_from_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned PPN_W = 21,
  parameter int unsigned PTE_W = 64,
  localparam int unsigned VPN_W     = IDX_W * LEVELS,
  localparam int unsigned ENTRY_LG2 = $clog2(PTE_W / 8),
  localparam int unsigned PA_W      = PPN_W + IDX_W + ENTRY_LG2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [VPN_W-1:0]     req_vpn,
  input  logic [PPN_W-1:0]     req_base,
  input  logic [1:0]           req_access,
  output logic                 busy,
  output logic                 mem_req_valid,
  output logic [PA_W-1:0]      mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [PTE_W-1:0]     mem_rsp_data,
  output logic                 done_valid,
  output logic [PPN_W-1:0]     done_ppn,
  output logic [PERM_W-1:0]    done_perm,
  output logic                 fault_page,
  output logic                 fault_prot,
  output logic [LVL_NUM_W-1:0] fault_level
);

  // Entry address by concatenation only: table page, index, zero byte offset.
  function automatic logic [PA_W-1:0] entry_addr(logic [PPN_W-1:0] tbl, logic [IDX_W-1:0] ix);
    return {tbl, ix, {ENTRY_LG2{1'b0}}};
  endfunction

  walk_state_e          state_q;
  logic                 accept;
  logic                 rsp_take;
  logic [LVL_NUM_W-1:0] cur_level;
  logic [IDX_W-1:0]     cur_idx;

  logic [VPN_W-1:0]     vpn_q;
  access_e              acc_q;
  logic [PPN_W-1:0]     tbl_ppn_q;
  logic [PPN_W-1:0]     res_ppn_q;
  logic [PERM_W-1:0]    res_perm_q;
  logic [LVL_NUM_W-1:0] flt_level_q;
  logic                 flt_prot_q;

  logic [PERM_W-1:0]    ev_perm;
  logic [PPN_W-1:0]     ev_ppn;
  logic                 ev_page;
  logic                 ev_prot;
  logic                 ev_last;

  assign cur_level = state_level(state_q);
  assign ev_last   = (state_q == ST_L3);

  pt_walk_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .rsp_valid    (mem_rsp_valid),
    .ev_page      (ev_page),
    .ev_prot      (ev_prot),
    .state_q      (state_q),
    .busy         (busy),
    .mem_req_valid(mem_req_valid),
    .accept       (accept),
    .rsp_take     (rsp_take)
  );

  pt_index_mux #(
    .IDX_W(IDX_W),
    .NLVL (LEVELS)
  ) u_idx (
    .vpn  (vpn_q),
    .level(cur_level),
    .idx  (cur_idx)
  );

  pt_entry_eval #(
    .PTE_W(PTE_W),
    .PPN_W(PPN_W)
  ) u_eval (
    .pte       (mem_rsp_data),
    .last_level(ev_last),
    .access    (acc_q),
    .perm      (ev_perm),
    .ppn       (ev_ppn),
    .page_fault(ev_page),
    .prot_fault(ev_prot)
  );

  assign mem_req_addr = entry_addr(tbl_ppn_q, cur_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q       <= '0;
      acc_q       <= ACC_READ;
      tbl_ppn_q   <= '0;
      res_ppn_q   <= '0;
      res_perm_q  <= '0;
      flt_level_q <= '0;
      flt_prot_q  <= 1'b0;
    end else begin
      if (accept) begin
        vpn_q     <= req_vpn;
        acc_q     <= access_e'(req_access);
        tbl_ppn_q <= req_base;
      end else if (rsp_take) begin
        if (ev_page || ev_prot) begin
          flt_level_q <= cur_level;
          flt_prot_q  <= !ev_page;
        end else begin
          tbl_ppn_q <= ev_ppn;
          if (ev_last) begin
            res_ppn_q  <= ev_ppn;
            res_perm_q <= ev_perm;
          end
        end
      end
    end
  end

  assign done_valid  = (state_q == ST_DONE);
  assign fault_page  = (state_q == ST_FAULT) && !flt_prot_q;
  assign fault_prot  = (state_q == ST_FAULT) && flt_prot_q;
  assign done_ppn    = res_ppn_q;
  assign done_perm   = res_perm_q;
  assign fault_level = flt_level_q;

  // R8: success is only reported right after an entry response.
  assert_done_after_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(mem_rsp_valid));

  // R5: a fault is only reported right after an entry response.
  assert_fault_after_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_page || fault_prot) |-> $past(mem_rsp_valid));

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [29:0] req_vpn = '0;
  logic [20:0] req_base = '0;
  logic [1:0]  req_access = '0;
  logic        busy;
  logic        mem_req_valid;
  logic [33:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done_valid;
  logic [20:0] done_ppn;
  logic [2:0]  done_perm;
  logic        fault_page;
  logic        fault_prot;
  logic [1:0]  fault_level;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
    .req_base(req_base), .req_access(req_access), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_ppn(done_ppn), .done_perm(done_perm),
    .fault_page(fault_page), .fault_prot(fault_prot), .fault_level(fault_level)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_pte(logic [20:0] ppn, logic [2:0] perm, logic v);
    return {ppn, 39'd0, perm, v};
  endfunction

  function automatic logic [63:0] exp_addr(logic [20:0] ppn, int unsigned idx);
    return {43'd0, ppn} * 64'd8192 + 64'(idx) * 64'd8;
  endfunction

  function automatic logic [2:0] need_of(logic [1:0] acc);
    if (acc == 2'd1) return 3'b010;
    if (acc == 2'd2) return 3'b100;
    return 3'b001;
  endfunction

  // Starts at a falling edge, ends at the falling edge of the reporting cycle.
  task automatic walk(input logic [29:0] vpn, input logic [20:0] base, input logic [1:0] acc,
                      input logic [63:0] e1, input logic [63:0] e2, input logic [63:0] e3,
                      input int lat, input bit noise);
    logic [20:0] tbl = base;
    bit          fin = 0;
    req_valid = 1'b1; req_vpn = vpn; req_base = base; req_access = acc;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", "busy after accept", 64'(busy), 64'd1);
    for (int lvl = 1; lvl <= 3 && !fin; lvl++) begin
      int unsigned idx = (int'(vpn) >> (10 * (3 - lvl))) & 1023;
      logic [63:0] e = (lvl == 1) ? e1 : (lvl == 2) ? e2 : e3;
      chk("R3", "read issued", 64'(mem_req_valid), 64'd1);
      chk("R2", "entry address", 64'(mem_req_addr), exp_addr(tbl, idx));
      if (noise) begin
        req_valid = 1'b1; req_vpn = ~vpn; req_base = ~base; req_access = ~acc;
      end
      @(negedge clk);
      chk("R3", "single read pulse", 64'(mem_req_valid), 64'd0);
      repeat (lat) @(negedge clk);
      chk("R1", "busy while waiting", 64'(busy), 64'd1);
      req_valid = 1'b0;
      mem_rsp_valid = 1'b1; mem_rsp_data = e;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = ~e;
      if (!e[0]) begin
        fin = 1;
        chk("R5", "page fault", 64'(fault_page), 64'd1);
        chk("R5", "no prot fault on invalid", 64'(fault_prot), 64'd0);
        chk("R5", "fault level", 64'(fault_level), 64'(lvl));
        chk("R5", "no read after fault", 64'(mem_req_valid), 64'd0);
      end else if (lvl < 3 && !e[1]) begin
        fin = 1;
        chk("R6", "table read denied", 64'(fault_prot), 64'd1);
        chk("R6", "fault level", 64'(fault_level), 64'(lvl));
      end else if (lvl == 3 && ((e[3:1] & need_of(acc)) != need_of(acc))) begin
        fin = 1;
        chk("R7", "permission denied", 64'(fault_prot), 64'd1);
        chk("R7", "fault level", 64'(fault_level), 64'd3);
        chk("R7", "no done", 64'(done_valid), 64'd0);
      end else if (lvl == 3) begin
        fin = 1;
        chk("R8", "done", 64'(done_valid), 64'd1);
        chk("R8", "ppn", 64'(done_ppn), 64'(e[63:43]));
        chk("R8", "perm", 64'(done_perm), 64'(e[3:1]));
        chk("R7", "no fault on grant", 64'({fault_page, fault_prot}), 64'd0);
      end else begin
        tbl = e[63:43];
      end
    end
    chk("R1", "busy low when reporting", 64'(busy), 64'd0);
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk("R8", "result is one pulse", 64'({done_valid, fault_page, fault_prot}), 64'd0);
    chk("R1", "idle not busy", 64'(busy), 64'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "reset outputs", 64'({busy, mem_req_valid, done_valid, fault_page, fault_prot}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "outputs after reset", 64'({busy, mem_req_valid, done_valid, fault_page, fault_prot}), 64'd0);

    // R3: response with nothing outstanding is ignored
    mem_rsp_valid = 1'b1; mem_rsp_data = mk_pte(21'h1234, 3'b111, 1'b1);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R3", "stray response ignored", 64'({busy, mem_req_valid, done_valid, fault_page, fault_prot}), 64'd0);

    // R4 R7 R8: every access code against every final permission set
    for (int a = 0; a < 4; a++) begin
      for (int p = 0; p < 8; p++) begin
        int unsigned k = unsigned'(a * 8 + p);
        logic [29:0] vpn  = 30'((k * 32'h0123_4567) ^ 32'h2AB5_5A5A);
        logic [20:0] base = 21'(k * 999 + 17);
        logic [20:0] p1   = 21'(base * 3 + 1);
        logic [20:0] p2   = 21'(base * 5 + 2);
        logic [20:0] p3   = base ^ 21'h1F_FFFF;
        walk(vpn, base, 2'(a), mk_pte(p1, 3'b001, 1'b1), mk_pte(p2, 3'b001, 1'b1),
             mk_pte(p3, 3'(p), 1'b1), (a + p) % 3, a == 2);
        if (p % 2 == 0) idle_check();
      end
    end
    idle_check();

    // R5: invalid entry at each level, priority over permission
    for (int l = 1; l <= 3; l++) begin
      logic [63:0] good = mk_pte(21'h0ABCD, 3'b111, 1'b1);
      logic [63:0] bad  = mk_pte(21'h1FFFF, 3'b111, 1'b0);
      walk(30'h3FFF_FFFF, 21'h1F_FFFF, 2'd1, (l == 1) ? bad : good, (l == 2) ? bad : good,
           (l == 3) ? bad : good, l - 1, 1'b1);
      idle_check();
    end

    // R6: intermediate entry without read at level 1 and level 2
    walk(30'h0000_0000, 21'h00000, 2'd0, mk_pte(21'h00055, 3'b110, 1'b1),
         mk_pte(21'h0, 3'b111, 1'b1), mk_pte(21'h0, 3'b111, 1'b1), 0, 1'b0);
    walk(30'h1555_5555, 21'h15555, 2'd2, mk_pte(21'h1AAAA, 3'b001, 1'b1),
         mk_pte(21'h00077, 3'b110, 1'b1), mk_pte(21'h0, 3'b111, 1'b1), 2, 1'b0);
    idle_check();

    // R2 R8: all-ones pages chained straight into a zero walk
    walk(30'h3FFF_FFFF, 21'h1F_FFFF, 2'd3, mk_pte(21'h1F_FFFF, 3'b001, 1'b1),
         mk_pte(21'h1F_FFFF, 3'b001, 1'b1), mk_pte(21'h1F_FFFF, 3'b001, 1'b1), 0, 1'b0);
    walk(30'h0000_0000, 21'h00000, 2'd2, mk_pte(21'h00000, 3'b001, 1'b1),
         mk_pte(21'h00000, 3'b001, 1'b1), mk_pte(21'h00000, 3'b100, 1'b1), 1, 1'b0);
    idle_check();

    finish_run();
  end

endmodule